// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable synchronous static memory. Each command it samples on a rising clock edge is followed by its data transfer in the next clock cycle. Reads and writes therefore alternate on the shared data bus with no idle cycle between them. The word is made of byte lanes of nine bits each, four by default, and the depth is set by a parameter. The bidirectional bus appears as three ports: write data in, read data out, and a drive enable.

A command is a load or an advance. A load samples an address and a read/write select, and it starts an operation only when all three chip selects are active. An advance continues the last operation as a four-beat burst, or it is a no-op when the core is deselected. Read data flows straight from the array during the data cycle, with no output register. An active-low clock enable stalls the whole pipeline. An asynchronous output enable can turn off the bus drivers at any time.

Top module: `zbt_sram_core`

## Requirements
- R1: After a load command with `rd_wr`=1 and all chip selects active, the next cycle drives `rdata_oe`=1 with `rdata` equal to the array word at that address, taken without an output register.
- R2: After a load command with `rd_wr`=0, the `wdata` present in the next cycle is written at the next enabled clock edge. Lane i is bits [9i+8:9i]. Only lanes whose `lane_we_n` bit was 0 in the command cycle change.
- R3: Read and write commands may be issued in consecutive cycles in any mix with no idle cycle, and a read issued right after a write to the same address returns the newly written data.
- R4: A load is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise the core becomes deselected, while a transfer already pending still completes in its data cycle.
- R5: `rdata_oe` is 0 in the cycle after a deselecting load and in the cycle after a write command.
- R6: While `oe_n`=1, `rdata_oe` is 0 at once, whatever the pipeline state.
- R7: At a clock edge where `cke_n`=1, all synchronous inputs are ignored: no write is committed, and the pending operation, its address and `rdata` stay unchanged.
- R8: With `adv_ld`=1 after a read or write, `rd_wr` is ignored and the same operation type continues. The address keeps its upper bits, and the two low bits become (base+k) mod 4 when `BURST_ILV`=0, or base XOR k when `BURST_ILV`=1, where k counts the advances since the load.
- R9: With `adv_ld`=1 while deselected, nothing starts and the bus stays undriven.
- R10: While `rst_n`=0 and at its release, the core is deselected and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; 1 stalls the core |
| addr | input | ADDR_W | Address sampled on a load |
| rd_wr | input | 1 | 1 = read, 0 = write (loads only) |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data for the current data cycle |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |

## Verification
The bench builds two copies of the core side by side, both with `ADDR_W`=6: one with linear burst order and one with interleaved order, driven by the same stimulus. The 64-word array lets random addresses collide often, so read-after-write, lane merging over earlier data and bursts that wrap inside a four-word group all occur many times. Comparing the two copies against their own expected address sequences checks both burst orders in one run.

// File: rtl/zbt_pkg.sv
// Shared definitions for the zero-turnaround SRAM core.
// Assumes a fixed burst of four beats (two counter bits).
package zbt_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_kind_e;
endpackage

// File: rtl/zbt_cmd_pipe.sv
// Command stage: registers each command for its data cycle one clock later.
// A load captures a new operation or deselects. An advance keeps the
// operation type and steps the burst counter. cke_n=1 freezes every register.
// Assumes that sel is already the AND of the three chip selects.
module zbt_cmd_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_wr,
    input  logic                 adv_ld,
    input  logic                 sel,
    input  logic [LANES-1:0]     lane_we_n,
    output op_kind_e             kind,
    output logic [ADDR_W-1:0]    base,
    output logic [BURST_W-1:0]   cnt,
    output logic [LANES-1:0]     lane_n
);
    // Command register: load, advance, deselect and stall handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind   <= OP_IDLE;
            base   <= '0;
            cnt    <= '0;
            lane_n <= '1;
        end else if (!cke_n) begin
            if (!adv_ld) begin
                lane_n <= lane_we_n;
                if (sel) begin
                    kind <= rd_wr ? OP_RD : OP_WR;
                    base <= addr;
                    cnt  <= '0;
                end else begin
                    kind <= OP_IDLE;
                end
            end else if (kind != OP_IDLE) begin
                lane_n <= lane_we_n;
                cnt    <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/zbt_burst_addr.sv
// Burst address generator: combines the loaded base address with the beat
// counter. The parameter picks linear (wrapping add) or interleaved (XOR)
// order on the two low bits. Assumes ADDR_W >= 2.
module zbt_burst_addr
    import zbt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter bit BURST_ILV = 1'b0
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] cnt,
    output logic [ADDR_W-1:0]  cur_addr
);
    logic [BURST_W-1:0] low;

    generate
        if (BURST_ILV) begin : g_ilv
            // Interleaved order: XOR the beat count into the low bits
            always_comb low = base[BURST_W-1:0] ^ cnt;
        end else begin : g_lin
            // Linear order: add the beat count, wrapping in the group
            always_comb low = base[BURST_W-1:0] + cnt;
        end
    endgenerate

    // Keep the upper bits of the loaded address
    always_comb cur_addr = {base[ADDR_W-1:BURST_W], low};
endmodule

// File: rtl/zbt_array.sv
// Storage array: one memory per byte lane, each written on its own lane
// enable at the clock edge, read combinationally (flow-through).
// Assumes the caller gates wr_en with the clock enable.
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         lane_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write: only when this lane's enable is active
        always_ff @(posedge clk) begin
            if (wr_en && !lane_n[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
        end

        // Lane read: straight from the array
        always_comb rdata[i*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/zbt_sram_core.sv
// Top of the zero-turnaround SRAM core. Each command is sampled on a rising
// edge and its data transfer takes place in the following cycle, so read
// and write cycles mix with no idle cycle. Assumes the external bus driver
// uses rdata_oe to drive rdata onto the shared bus.
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LANES     = 4,
    parameter int LANE_W    = 9,
    parameter bit BURST_ILV = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_wr,
    input  logic                     adv_ld,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic [LANES-1:0]         lane_we_n,
    input  logic                     oe_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_oe
);
    localparam int DATA_W = LANES * LANE_W;

    op_kind_e           op_kind;
    logic [ADDR_W-1:0]  op_base;
    logic [BURST_W-1:0] op_cnt;
    logic [LANES-1:0]   op_lane_n;
    logic [ADDR_W-1:0]  cur_addr;
    logic               sel;
    logic               wr_en;

    // Chip selected only when all three selects are active
    always_comb sel = !ce1_n && ce2 && !ce3_n;

    zbt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .addr      (addr),
        .rd_wr     (rd_wr),
        .adv_ld    (adv_ld),
        .sel       (sel),
        .lane_we_n (lane_we_n),
        .kind      (op_kind),
        .base      (op_base),
        .cnt       (op_cnt),
        .lane_n    (op_lane_n)
    );

    zbt_burst_addr #(.ADDR_W(ADDR_W), .BURST_ILV(BURST_ILV)) u_addr (
        .base     (op_base),
        .cnt      (op_cnt),
        .cur_addr (cur_addr)
    );

    // Commit the write at the edge that closes its data cycle
    always_comb wr_en = !cke_n && (op_kind == OP_WR) && rst_n;

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .addr   (cur_addr),
        .lane_n (op_lane_n),
        .wdata  (wdata),
        .rdata  (rdata)
    );

    // Drive the bus only in a read data cycle with the output enable active
    always_comb rdata_oe = (op_kind == OP_RD) && !oe_n;
endmodule

// File: rtl/zbt_sram_chk.sv
// Checker for zbt_sram_core, bound to every instance. Relates the command
// ports to the registered operation and the bus enable one cycle later.
module zbt_sram_chk #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          rd_wr,
    input  logic          adv_ld,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          oe_n,
    input  logic [DW-1:0] rdata,
    input  logic          rdata_oe,
    input  logic [1:0]    op_kind
);
    logic chip_on;
    always_comb chip_on = !ce1_n && ce2 && !ce3_n;

    // R10
    reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !rdata_oe);

    // R6
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe);

    // R5
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && chip_on && !rd_wr) |=> !rdata_oe);

    // R4
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !chip_on) |=> (op_kind == 2'd0) && !rdata_oe);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(op_kind) && $stable(rdata));

    // R8
    burst_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && op_kind != 2'd0) |=> op_kind == $past(op_kind));

    // R9
    noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && op_kind == 2'd0) |=> (op_kind == 2'd0) && !rdata_oe);
endmodule

bind zbt_sram_core zbt_sram_chk #(.DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .rd_wr    (rd_wr),
    .adv_ld   (adv_ld),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .oe_n     (oe_n),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .op_kind  (op_kind)
);

// File: tb/zbt_sram_core_tb.sv
// Bench: a linear and an interleaved core on shared stimulus, each checked
// against its own expected memory and address sequence.
module zbt_sram_core_tb;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic rd_wr = 1'b1;
    logic adv_ld = 1'b0;
    logic ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic [3:0] lane_we_n = 4'hF;
    logic oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_lin, rd_ilv;
    logic oe_lin, oe_ilv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zbt_sram_core #(.ADDR_W(AW), .BURST_ILV(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .addr(addr), .rd_wr(rd_wr),
        .adv_ld(adv_ld), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .lane_we_n(lane_we_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rd_lin), .rdata_oe(oe_lin));

    zbt_sram_core #(.ADDR_W(AW), .BURST_ILV(1'b1)) u_dut_ilv (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .addr(addr), .rd_wr(rd_wr),
        .adv_ld(adv_ld), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .lane_we_n(lane_we_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rd_ilv), .rdata_oe(oe_ilv));

    // Expected state: 0 idle, 1 read, 2 write
    int m_kind = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;
    logic [3:0] m_lane = 4'hF;
    logic [DW-1:0] ref_lin [DEPTH];
    logic [DW-1:0] ref_ilv [DEPTH];

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] k, bit ilv);
        logic [1:0] lo;
        lo = ilv ? (b[1:0] ^ k) : (b[1:0] + k);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] ln);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < 4; i++) if (!ln[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive command and data at the falling edge, check the
    // current data cycle, then advance the expected state at the rising edge.
    task automatic step(bit rd, bit adv, bit desel, logic [3:0] ln, logic [AW-1:0] a,
                        bit stall, bit oen, string tag);
        logic [AW-1:0] al, ai;
        @(negedge clk);
        rd_wr = rd; adv_ld = adv; addr = a; lane_we_n = ln; cke_n = stall; oe_n = oen;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        if (desel) begin
            case ($urandom_range(2))
                0: ce1_n = 1'b1;
                1: ce2 = 1'b0;
                default: ce3_n = 1'b1;
            endcase
        end
        wdata = {$urandom, $urandom};
        #1;
        al = beat_addr(m_base, m_cnt, 1'b0);
        ai = beat_addr(m_base, m_cnt, 1'b1);
        chk(tag, {35'd0, oe_lin}, {35'd0, (m_kind == 1) && !oen});
        chk(tag, {35'd0, oe_ilv}, {35'd0, (m_kind == 1) && !oen});
        if (m_kind == 1 && !oen) begin
            chk(tag, rd_lin, ref_lin[al]);
            chk(tag, rd_ilv, ref_ilv[ai]);
        end
        @(posedge clk);
        if (!stall) begin
            if (m_kind == 2) begin
                ref_lin[al] = merge(ref_lin[al], wdata, m_lane);
                ref_ilv[ai] = merge(ref_ilv[ai], wdata, m_lane);
            end
            if (!adv) begin
                m_lane = ln;
                if (!desel) begin
                    m_kind = rd ? 1 : 2; m_base = a; m_cnt = 2'd0;
                end else m_kind = 0;
            end else if (m_kind != 0) begin
                m_lane = ln; m_cnt = m_cnt + 2'd1;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h0051_3a7c));
        // R10: reset holds the bus undriven
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", {35'd0, oe_lin}, 36'd0);
        chk("R10", {35'd0, oe_ilv}, 36'd0);
        rst_n = 1'b1;
        // R2 / R5: fill every word with full-lane writes
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b0, 1'b0, 4'h0, a[AW-1:0], 1'b0, 1'b0, "R5");
        // R1: single load read
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd5, 1'b0, 1'b0, "R1");
        // R2: write lanes 0 and 2 only, then R3: read it back at once
        step(1'b0, 1'b0, 1'b0, 4'b1010, 6'd9, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd9, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, 4'h0, 6'd9, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd9, 1'b0, 1'b0, "R3");
        // R8: burst read from address 6, rd_wr toggled during the advances
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd6, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b0, 4'hF, 6'd0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, 4'hF, 6'd0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, 4'hF, 6'd0, 1'b0, 1'b0, "R8");
        // R8: burst write from 13, then R4: deselect while it completes
        step(1'b0, 1'b0, 1'b0, 4'h0, 6'd13, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b0, 4'h0, 6'd0, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, "R4");
        // R9: advance while deselected stays a no-op
        step(1'b1, 1'b1, 1'b0, 4'hF, 6'd0, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd14, 1'b0, 1'b0, "R9");
        // R4: pending read completes after a deselecting load
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, "R4");
        // R7: write command, then stall while other inputs change
        step(1'b0, 1'b0, 1'b0, 4'h0, 6'd20, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd21, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd20, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd33, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd33, 1'b1, 1'b0, "R7");
        // R6: output enable off during a read data cycle
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd2, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd2, 1'b0, 1'b1, "R6");
        // R3: constrained random mix
        for (int n = 0; n < 4000; n++) begin
            step($urandom_range(1), $urandom_range(99) < 35, $urandom_range(99) < 10,
                 4'($urandom), AW'($urandom), $urandom_range(99) < 10,
                 $urandom_range(99) < 10, "R3");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule